// File: doc/BRIEF.md
# Fault Status Capture Register

This block holds the status of the fault inputs of one PWM generator in a single register. Each raw fault input is first passed through a synchroniser. It is then given a per-input polarity, so that either level can count as active. A view-select control sets what the register shows:

- **Live view:** the register shows the current adjusted levels.
- **Latched view:** each bit is sticky and records that its input has gone active at some point. Software clears a latched bit by writing 1 to it.

A separate extension enable must be set for any write to take effect. The status always follows every fault input. No per-source enable of the generator masks it.

Software reads the register through a plain read-data port and writes it with a write strobe and write data. Write data has effect only while both the latched view and the extension enable are set.

Top module: `fault_status_reg`

## Requirements
- R1: The register is REG_W (16) bits wide. Bit i (i = 0..3) holds fault input i. Bits 15..4 always read 0, and writes to them change nothing.
- R2: While reset is asserted, and on the first read after it, all status bits are 0, given that the polarity mask is 0.
- R3: With the view select at 0 (live view), bit i reads as the synchronised raw input XOR polarity bit i. The read shows a raw change after exactly 2 rising clock edges. Writes have no effect on what is read.
- R4: With the view select at 1 (latched view), bit i reads 1 from the edge after its adjusted input is 1. This holds even when the input was active for a single cycle. The bit keeps reading 1 until it is cleared.
- R5: In the latched view, with the extension enable at 1, a write with data bit i = 1 clears bit i at the next edge. A data bit of 0 leaves its bit unchanged.
- R6: While the extension enable is 0, writes leave every status bit unchanged.
- R7: If a clear and an active adjusted input land on the same bit in the same cycle, the bit stays 1.
- R8: The sticky bits keep capturing while the live view is selected. Switching to the latched view shows every bit that was captured and not cleared.
- R9: A polarity bit of 1 makes a low raw level active. A polarity bit of 0 makes a high raw level active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_raw | input | N_FLT (4) | Raw fault inputs, asynchronous |
| flt_pol | input | N_FLT (4) | Per-input polarity; 1 inverts |
| view_latch | input | 1 | 0: live view, 1: latched view |
| ext_en | input | 1 | Extension enable; gates all writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | REG_W (16) | Write data; 1 bits clear in latched view |
| rd_data | output | REG_W (16) | Register read value |

## Verification
The bench builds the block with its default parameters: four fault inputs, a 16-bit register and a two-stage synchroniser. At these values the full range of the polarity and clear masks is within reach of random stimulus. The two-edge latency is short enough that single-cycle pulses, view switches and write collisions can be placed on exact edges. The reserved upper twelve bits are wide enough for random write data to try to disturb them on almost every write.

// File: rtl/fault_stat_pkg.sv
package fault_stat_pkg;
   typedef enum logic {
      VIEW_LIVE  = 1'b0,
      VIEW_LATCH = 1'b1
   } view_e;

   localparam int unsigned DEF_N_FLT  = 4;
   localparam int unsigned DEF_REG_W  = 16;
   localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   localparam int unsigned LAST = STAGES - 1;

   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("fault_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end

      // R3
      stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (stg[s] == $past(stg[s-1])));
   end

   assign d_out = stg[LAST];
endmodule

// File: rtl/fault_sense.sv
module fault_sense #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] pol,
   output logic [W-1:0] act
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
         act[i] = pol[i] ? ~lvl[i] : lvl[i];
      end
   end
endmodule

// File: rtl/fault_sticky.sv
module fault_sticky #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] act,
   input  logic [W-1:0] clr,
   output logic [W-1:0] held
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      held[i] <= 1'b0;
         else if (act[i]) held[i] <= 1'b1;
         else if (clr[i]) held[i] <= 1'b0;
      end
   end

   // R4 R7
   capture_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((held & $past(act)) == $past(act)));

   // R5
   clear_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((held & $past(clr & ~act)) == '0));

   // R4
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((held & ~$past(held) & ~$past(act)) == '0));
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
   import fault_stat_pkg::*;
#(
   parameter int unsigned N_FLT  = DEF_N_FLT,
   parameter int unsigned REG_W  = DEF_REG_W,
   parameter int unsigned STAGES = DEF_STAGES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_FLT-1:0] flt_raw,
   input  logic [N_FLT-1:0] flt_pol,
   input  logic             view_latch,
   input  logic             ext_en,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data
);
   localparam int unsigned RSV_W = REG_W - N_FLT;

   if (N_FLT < 1 || N_FLT >= REG_W) begin : g_bad_width
      $error("fault_status_reg: need 1 <= N_FLT < REG_W");
   end

   view_e            view;
   logic [N_FLT-1:0] lvl_sync;
   logic [N_FLT-1:0] act;
   logic [N_FLT-1:0] clr;
   logic [N_FLT-1:0] held;
   logic [N_FLT-1:0] shown;
   logic             wr_ok;

   assign view = view_e'(view_latch);

   fault_sync #(.W(N_FLT), .STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (flt_raw),
      .d_out (lvl_sync)
   );

   fault_sense #(.W(N_FLT)) u_sense (
      .lvl (lvl_sync),
      .pol (flt_pol),
      .act (act)
   );

   always_comb begin
      wr_ok = wr_en && ext_en && (view == VIEW_LATCH);
      clr   = wr_ok ? wr_data[N_FLT-1:0] : '0;
   end

   fault_sticky #(.W(N_FLT)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .clr   (clr),
      .held  (held)
   );

   always_comb begin
      unique case (view)
         VIEW_LATCH: shown = held;
         default:    shown = act;
      endcase
   end

   assign rd_data = {{RSV_W{1'b0}}, shown};

   // R6
   write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && ext_en && view_latch) |=> ((~held & $past(held)) == '0));

   // R8
   view_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(view_latch) && $stable(held)) |-> (rd_data[N_FLT-1:0] == $past(held)));
endmodule

// File: tb/fault_status_reg_test.sv
`timescale 1ns/1ps
module fault_status_reg_test;
   localparam int N = 4;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] flt_raw = '0;
   logic [N-1:0] flt_pol = '0;
   logic         view_latch = 1'b0;
   logic         ext_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   fault_status_reg uut (
      .clk(clk), .rst_n(rst_n), .flt_raw(flt_raw), .flt_pol(flt_pol),
      .view_latch(view_latch), .ext_en(ext_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data)
   );

   // reference state built from the requirements: 2-edge latency, set wins
   logic [N-1:0] m_d1, m_d2, m_st;

   function automatic logic [N-1:0] clr_of(logic we, logic ee, logic lt, logic [W-1:0] wd);
      return (we && ee && lt) ? wd[N-1:0] : '0;
   endfunction

   function automatic logic [W-1:0] expect_rd(logic lt, logic [N-1:0] lv,
                                              logic [N-1:0] pol, logic [N-1:0] st);
      return lt ? {{(W-N){1'b0}}, st} : {{(W-N){1'b0}}, lv ^ pol};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_d1 <= '0; m_d2 <= '0; m_st <= '0;
      end else begin
         m_d1 <= flt_raw;
         m_d2 <= m_d1;
         m_st <= (m_st & ~clr_of(wr_en, ext_en, view_latch, wr_data)) | (m_d2 ^ flt_pol);
      end
   end

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_model(string req);
      chk(req, rd_data, expect_rd(view_latch, m_d2, flt_pol, m_st));
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog: expired, expected run to end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      process::self().srandom(32'd4711);
      flt_raw = 4'hF;
      repeat (3) nxt();
      chk("R2 reset", rd_data, 16'h0000);
      rst_n = 1'b1;
      flt_raw = 4'h0;
      nxt();
      chk("R2 after reset", rd_data, 16'h0000);

      // R3 live view with two-edge latency
      flt_raw = 4'b0101;
      nxt();
      chk("R3 latency edge1", rd_data, 16'h0000);
      nxt();
      chk("R3 latency edge2", rd_data, 16'h0005);
      // R9 polarity inverts
      flt_pol = 4'b0011;
      #0.5;
      chk("R9 polarity", rd_data, 16'h0006);
      flt_pol = 4'b0000;
      // R3 writes ignored in live view
      ext_en = 1'b1; wr_en = 1'b1; wr_data = 16'hFFFF;
      nxt();
      wr_en = 1'b0;
      chk("R3 live write no effect", rd_data, 16'h0005);

      // R8 background capture: switch to latched view
      flt_raw = 4'b0000;
      repeat (3) nxt();
      chk("R3 live follows low", rd_data, 16'h0000);
      view_latch = 1'b1;
      #0.5;
      chk("R8 captured on entry", rd_data, 16'h0005);

      // R5 clear bit0 only; bit2 stays
      wr_en = 1'b1; wr_data = 16'h0001;
      nxt();
      wr_en = 1'b0;
      chk("R5 clear one bit", rd_data, 16'h0004);
      // R6 writes ignored while enable is clear
      ext_en = 1'b0; wr_en = 1'b1; wr_data = 16'hFFFF;
      nxt();
      wr_en = 1'b0;
      chk("R6 write gated", rd_data, 16'h0004);
      ext_en = 1'b1; wr_en = 1'b1; wr_data = 16'hFFF4;
      nxt();
      wr_en = 1'b0;
      chk("R1 reserved read zero", rd_data, 16'h0000);

      // R4 single-cycle pulse on bit1
      flt_raw = 4'b0010;
      nxt();
      flt_raw = 4'b0000;
      nxt(); nxt();
      chk("R4 pulse captured", rd_data, 16'h0002);
      repeat (4) nxt();
      chk("R4 pulse held", rd_data, 16'h0002);

      // R7 collision: bit3 active while cleared
      flt_raw = 4'b1000;
      repeat (3) nxt();
      chk("R4 level captured", rd_data, 16'h000A);
      wr_en = 1'b1; wr_data = 16'h000A;
      nxt();
      wr_en = 1'b0;
      chk("R7 set wins", rd_data, 16'h0008);
      flt_raw = 4'b0000;
      repeat (2) nxt();
      wr_en = 1'b1; wr_data = 16'h0008;
      nxt();
      wr_en = 1'b0;
      chk("R5 clear after release", rd_data, 16'h0000);

      // random phase
      for (int k = 0; k < 4000; k++) begin
         nxt();
         chk_model(view_latch ? "R4 R5 R6 R7 random latched" : "R3 R8 random live");
         total++;
         if (rd_data[W-1:N] !== '0) begin
            bad++;
            $display("FAIL R1 reserved: rd_data=%h expected upper zero", rd_data);
         end
         flt_raw = (($urandom % 8) == 0) ? N'($urandom) : '0;
         if (($urandom % 50) == 0) flt_pol = N'($urandom);
         if (($urandom % 30) == 0) view_latch = ~view_latch;
         ext_en  = ($urandom % 4) != 0;
         wr_en   = ($urandom % 3) == 0;
         wr_data = W'($urandom);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule